// File: doc/BRIEF.md
# Integer Address Generation Unit

This unit turns load and store requests into memory addresses and keeps the pointer registers that those addresses come from up to date. It holds its own file of 31 pointer-sized registers. A request names four of them (pointer, modifier, base and length), picks an update rule (linear, circular or bit-reversed) and a timing (address before or after the update), and gives an access size of one, two or four words. The modifier is scaled by the access size. The unit returns the address to drive toward memory, the updated pointer and whether that pointer was written back. It also flags a dual or quad address that is not aligned to its size.

Requests enter on a valid/ready handshake and results leave on a second valid/ready handshake. There is one output register. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high while no result is held, or while the held result is being taken in that same cycle. While `rsp_valid` is high and `rsp_ready` is low, every response field stays frozen and `req_ready` stays low. Registers are loaded through a plain write port. The write-back of an accepted request lands in the register file on the accepting edge, so a request in the very next cycle sees the new pointer.

Top module: `iagu`

## Requirements
- R1: Post-modify (`req_pre`=0): the response address equals the pointer register's value, the updated pointer is written back, and `rsp_wb_en` is 1.
- R2: Pre-modify (`req_pre`=1): the response address equals the updated pointer, and the write-back happens (with `rsp_wb_en`=1) only when `req_wb` is 1.
- R3: The step is the modifier register, read as two's complement, multiplied by the word count of `req_size` (00 gives one word, 01 gives two, 10 and 11 give four). Modes 00 and 11 are linear: updated pointer = pointer + step, modulo 2^32.
- R4: Circular mode (`req_mode`=01): given base <= pointer < base+length and |step| <= length, the updated pointer is base + ((pointer - base + step) mod length). The result is always inside [base, base+length), and base may have any value.
- R5: Bit-reverse mode (`req_mode`=10): the step is added with the carry running from bit 31 down toward bit 0. This equals the bit reversal of (reversed pointer + reversed step).
- R6: `rsp_align_fault` is 1 when the response address has bit 0 set for a two-word access, or has bits 1:0 not both zero for a four-word access. It is never set for a single-word access. The request still completes.
- R7: The registers are indices 0 to 30 and all reset to zero. Index 31 always reads as zero, and port writes or write-backs to index 31 are ignored.
- R8: A write-back is visible to a request accepted in the next cycle. When a port write and a write-back hit the same index on the same edge, the port write wins.
- R9: `rsp_valid` is 0 after reset. It is 1 in the cycle after an acceptance and falls once the response is taken with no new acceptance.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and every response field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_wr_en | input | 1 | Register file write strobe |
| rf_wr_idx | input | 5 | Register index to write |
| rf_wr_data | input | 32 | Value to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_ptr | input | 5 | Pointer register index |
| req_mod | input | 5 | Modifier register index |
| req_base | input | 5 | Circular base register index |
| req_len | input | 5 | Circular length register index |
| req_mode | input | 2 | 00/11 linear, 01 circular, 10 bit-reverse |
| req_pre | input | 1 | 1 = pre-modify, 0 = post-modify |
| req_wb | input | 1 | Write-back request for pre-modify |
| req_size | input | 2 | 00 one word, 01 two words, 10/11 four words |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 32 | Memory address |
| rsp_ptr_new | output | 32 | Updated pointer value |
| rsp_wb_en | output | 1 | Pointer was written back |
| rsp_wb_idx | output | 5 | Index that was written back |
| rsp_align_fault | output | 1 | Address misaligned for its size |

## Verification
Every response field is due one clock after the accepting edge. The bench drives requests on a falling edge and reads the response on the next falling edge, half a cycle after the register that holds it has loaded. Register contents are read back only through later requests, issued one cycle after the write or write-back they depend on, since a write-back is due at the accepting edge itself. The stall checks hold `rsp_ready` low and compare the held fields and `req_ready` on several falling edges in a row.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    AM_LINEAR  = 2'b00,
    AM_CIRC    = 2'b01,
    AM_BITREV  = 2'b10,
    AM_LINEAR2 = 2'b11
  } agu_mode_e;

  typedef enum logic [1:0] {
    SZ_ONE   = 2'b00,
    SZ_TWO   = 2'b01,
    SZ_FOUR  = 2'b10,
    SZ_FOUR2 = 2'b11
  } agu_size_e;

  localparam int SHIFT_W = 2;

  function automatic logic [SHIFT_W-1:0] size_shift(input agu_size_e sz);
    case (sz)
      SZ_ONE:  return 2'd0;
      SZ_TWO:  return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int NUM_REGS = 31,
  parameter int IDX_W    = 5,
  parameter int DATA_W   = 32,
  parameter int NRD      = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ext_we,
  input  logic [IDX_W-1:0]                ext_idx,
  input  logic [DATA_W-1:0]               ext_data,
  input  logic                            wb_we,
  input  logic [IDX_W-1:0]                wb_idx,
  input  logic [DATA_W-1:0]               wb_data,
  input  logic [NRD-1:0][IDX_W-1:0]       rd_idx,
  output logic [NRD-1:0][DATA_W-1:0]      rd_data
);

  localparam int MAX_IDX = (1 << IDX_W);

  initial begin
    if (NUM_REGS >= MAX_IDX) $error("agu_regfile: NUM_REGS must leave one index free");
  end

  logic [DATA_W-1:0] regs [NUM_REGS];

  // one flop row per register; the port write has priority over write-back
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_row
    logic hit_ext, hit_wb;
    assign hit_ext = ext_we && (ext_idx == IDX_W'(g));
    assign hit_wb  = wb_we  && (wb_idx  == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)       regs[g] <= '0;
      else if (hit_ext) regs[g] <= ext_data;
      else if (hit_wb)  regs[g] <= wb_data;
    end
  end

  // indices at or above NUM_REGS read as zero
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_comb begin
      rd_data[r] = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
        if (rd_idx[r] == IDX_W'(k)) rd_data[r] = regs[k];
      end
    end
  end

endmodule

// File: rtl/agu_scale.sv
module agu_scale
  import agu_pkg::*;
#(
  parameter int W = 32
) (
  input  agu_size_e        size,
  input  logic [W-1:0]     mod_val,
  output logic [W-1:0]     step,
  output logic [W-1:0]     align_mask
);

  logic [SHIFT_W-1:0] sh;

  always_comb begin
    sh         = size_shift(size);
    step       = mod_val << sh;
    align_mask = (W'(1) << sh) - W'(1);
  end

endmodule

// File: rtl/agu_update.sv
module agu_update
  import agu_pkg::*;
#(
  parameter int W = 32
) (
  input  agu_mode_e        mode,
  input  logic [W-1:0]     ptr,
  input  logic [W-1:0]     step,
  input  logic [W-1:0]     base,
  input  logic [W-1:0]     len,
  output logic [W-1:0]     nxt,
  output logic             circ_ok
);

  localparam int XW = W + 2;

  logic [W-1:0]          lin_res;
  logic [W-1:0]          circ_res;
  logic [W-1:0]          rev_res;
  logic [W-1:0]          off;
  logic [W-1:0]          step_mag;
  logic signed [XW-1:0]  noff;
  logic signed [XW-1:0]  lenx;

  assign lin_res = ptr + step;

  // circular: work on the offset inside the buffer, fold once either way
  always_comb begin
    off  = ptr - base;
    lenx = $signed({2'b00, len});
    noff = $signed({2'b00, off}) + $signed({{2{step[W-1]}}, step});
    if (noff >= lenx)        noff = noff - lenx;
    else if (noff < 0)       noff = noff + lenx;
    circ_res = base + noff[W-1:0];
    step_mag = step[W-1] ? (~step + W'(1)) : step;
    circ_ok  = (off < len) && (step_mag <= len);
  end

  // bit-reverse: ripple the carry from the top bit toward bit 0
  always_comb begin
    logic c;
    c = 1'b0;
    rev_res = '0;
    for (int i = W - 1; i >= 0; i--) begin
      rev_res[i] = ptr[i] ^ step[i] ^ c;
      c          = (ptr[i] & step[i]) | (c & (ptr[i] ^ step[i]));
    end
  end

  always_comb begin
    case (mode)
      AM_CIRC:   nxt = circ_res;
      AM_BITREV: nxt = rev_res;
      default:   nxt = lin_res;
    endcase
  end

endmodule

// File: rtl/iagu.sv
module iagu
  import agu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 31,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rf_wr_en,
  input  logic [IDX_W-1:0]  rf_wr_idx,
  input  logic [ADDR_W-1:0] rf_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_ptr,
  input  logic [IDX_W-1:0]  req_mod,
  input  logic [IDX_W-1:0]  req_base,
  input  logic [IDX_W-1:0]  req_len,
  input  logic [1:0]        req_mode,
  input  logic              req_pre,
  input  logic              req_wb,
  input  logic [1:0]        req_size,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ADDR_W-1:0] rsp_ptr_new,
  output logic              rsp_wb_en,
  output logic [IDX_W-1:0]  rsp_wb_idx,
  output logic              rsp_align_fault
);

  localparam int NRD    = 4;
  localparam int RD_PTR = 0;
  localparam int RD_MOD = 1;
  localparam int RD_BAS = 2;
  localparam int RD_LEN = 3;

  logic [NRD-1:0][IDX_W-1:0]  rd_idx;
  logic [NRD-1:0][ADDR_W-1:0] rd_data;
  logic [ADDR_W-1:0]          ptr_v, mod_v, base_v, len_v;
  logic [ADDR_W-1:0]          step, align_mask, nxt, addr_c;
  logic                       circ_ok, wb_c, fault_c, fire;
  agu_mode_e                  mode;
  agu_size_e                  size;

  assign mode = agu_mode_e'(req_mode);
  assign size = agu_size_e'(req_size);

  assign rd_idx[RD_PTR] = req_ptr;
  assign rd_idx[RD_MOD] = req_mod;
  assign rd_idx[RD_BAS] = req_base;
  assign rd_idx[RD_LEN] = req_len;
  assign ptr_v  = rd_data[RD_PTR];
  assign mod_v  = rd_data[RD_MOD];
  assign base_v = rd_data[RD_BAS];
  assign len_v  = rd_data[RD_LEN];

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  agu_regfile #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .DATA_W   (ADDR_W),
    .NRD      (NRD)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_we   (rf_wr_en),
    .ext_idx  (rf_wr_idx),
    .ext_data (rf_wr_data),
    .wb_we    (fire && wb_c),
    .wb_idx   (req_ptr),
    .wb_data  (nxt),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data)
  );

  agu_scale #(.W(ADDR_W)) u_scale (
    .size       (size),
    .mod_val    (mod_v),
    .step       (step),
    .align_mask (align_mask)
  );

  agu_update #(.W(ADDR_W)) u_upd (
    .mode    (mode),
    .ptr     (ptr_v),
    .step    (step),
    .base    (base_v),
    .len     (len_v),
    .nxt     (nxt),
    .circ_ok (circ_ok)
  );

  always_comb begin
    addr_c  = req_pre ? nxt : ptr_v;
    wb_c    = !req_pre || req_wb;
    fault_c = |(addr_c & align_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_addr        <= '0;
      rsp_ptr_new     <= '0;
      rsp_wb_en       <= 1'b0;
      rsp_wb_idx      <= '0;
      rsp_align_fault <= 1'b0;
    end else if (fire) begin
      rsp_valid       <= 1'b1;
      rsp_addr        <= addr_c;
      rsp_ptr_new     <= nxt;
      rsp_wb_en       <= wb_c;
      rsp_wb_idx      <= req_ptr;
      rsp_align_fault <= fault_c;
    end else if (rsp_ready) begin
      rsp_valid       <= 1'b0;
    end
  end

  AST_POST_ADDR_IS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !req_pre |=> rsp_addr == $past(ptr_v)); // R1

  AST_POST_WRITES_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !req_pre |=> rsp_wb_en); // R1

  AST_CIRC_STAYS_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (mode == AM_CIRC) && circ_ok |=>
      (rsp_ptr_new - $past(base_v)) < $past(len_v)); // R4

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) &&
      $stable(rsp_ptr_new) && $stable(rsp_align_fault) && $stable(rsp_wb_en)); // R10

endmodule

// File: tb/tb_iagu.sv
`timescale 1ns/1ps
module tb_iagu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rf_wr_en;
  logic [4:0]  rf_wr_idx;
  logic [31:0] rf_wr_data;
  logic        req_valid, req_ready;
  logic [4:0]  req_ptr, req_mod, req_base, req_len;
  logic [1:0]  req_mode, req_size;
  logic        req_pre, req_wb;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_addr, rsp_ptr_new;
  logic        rsp_wb_en, rsp_align_fault;
  logic [4:0]  rsp_wb_idx;

  int errors = 0;
  int checks = 0;
  bit [31:0] sh_rf [32];

  always #2.5 clk = ~clk;

  iagu dut (
    .clk(clk), .rst_n(rst_n),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_ptr(req_ptr), .req_mod(req_mod), .req_base(req_base), .req_len(req_len),
    .req_mode(req_mode), .req_pre(req_pre), .req_wb(req_wb), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_ptr_new(rsp_ptr_new), .rsp_wb_en(rsp_wb_en),
    .rsp_wb_idx(rsp_wb_idx), .rsp_align_fault(rsp_align_fault)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic bit [31:0] rev32(input bit [31:0] v);
    bit [31:0] o;
    for (int i = 0; i < 32; i++) o[i] = v[31-i];
    return o;
  endfunction

  function automatic bit [31:0] model_next(input bit [1:0] mode, input bit [31:0] p,
      input bit [31:0] st, input bit [31:0] b, input bit [31:0] l);
    longint off, s, n;
    bit [31:0] d;
    case (mode)
      2'b01: begin
        d   = p - b;
        off = longint'(d);
        s   = longint'($signed(st));
        n   = ((off + s) % longint'(l) + longint'(l)) % longint'(l);
        return b + n[31:0];
      end
      2'b10: return rev32(rev32(p) + rev32(st));
      default: return p + st;
    endcase
  endfunction

  task automatic wr(input logic [4:0] idx, input logic [31:0] val);
    rf_wr_en = 1'b1; rf_wr_idx = idx; rf_wr_data = val;
    @(posedge clk); @(negedge clk);
    rf_wr_en = 1'b0;
    if (idx != 5'd31) sh_rf[idx] = val;
  endtask

  task automatic drive(input bit [1:0] mode, input bit pre, input bit wbq, input bit [1:0] size,
                       input logic [4:0] pi, input logic [4:0] mi, input logic [4:0] bi,
                       input logic [4:0] li);
    req_valid = 1'b1; req_mode = mode; req_pre = pre; req_wb = wbq; req_size = size;
    req_ptr = pi; req_mod = mi; req_base = bi; req_len = li;
  endtask

  // one request with rsp_ready high; checked at the negedge after acceptance
  task automatic do_req(input bit [1:0] mode, input bit pre, input bit wbq, input bit [1:0] size,
                        input logic [4:0] pi, input logic [4:0] mi, input logic [4:0] bi,
                        input logic [4:0] li, input string tag);
    int sh;
    bit [31:0] st, nx, ad;
    bit wb, flt;
    string at;
    sh  = (size == 2'b00) ? 0 : (size == 2'b01) ? 1 : 2;
    st  = sh_rf[mi] << sh;
    nx  = model_next(mode, sh_rf[pi], st, sh_rf[bi], sh_rf[li]);
    ad  = pre ? nx : sh_rf[pi];
    wb  = !pre || wbq;
    flt = (sh == 1 && ad[0]) || (sh == 2 && ad[1:0] != 2'b00);
    at  = (tag != "") ? tag : (mode == 2'b01) ? "R4" : (mode == 2'b10) ? "R5" : pre ? "R2" : "R1";
    drive(mode, pre, wbq, size, pi, mi, bi, li);
    chk(req_ready == 1'b1, "R10", "req_ready idle", 32'(req_ready), 32'd1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R9", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rsp_addr == ad, at, "address", rsp_addr, ad);
    chk(rsp_ptr_new == nx, (mode == 2'b01) ? "R4" : (mode == 2'b10) ? "R5" : "R3",
        "updated pointer", rsp_ptr_new, nx);
    chk(rsp_wb_en == wb, pre ? "R2" : "R1", "write-back enable", 32'(rsp_wb_en), 32'(wb));
    chk(rsp_wb_idx == pi, "R1", "write-back index", 32'(rsp_wb_idx), 32'(pi));
    chk(rsp_align_fault == flt, "R6", "alignment fault", 32'(rsp_align_fault), 32'(flt));
    if (wb && pi != 5'd31) sh_rf[pi] = nx;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 32; i++) sh_rf[i] = '0;
    rst_n = 1'b0; rf_wr_en = 1'b0; rf_wr_idx = '0; rf_wr_data = '0;
    req_valid = 1'b0; req_ptr = '0; req_mod = '0; req_base = '0; req_len = '0;
    req_mode = '0; req_pre = 1'b0; req_wb = 1'b0; req_size = '0; rsp_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(negedge clk);

    // reset state
    chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R10", "req_ready after reset", 32'(req_ready), 32'd1);
    do_req(2'b00, 1'b0, 1'b0, 2'b00, 5'd5, 5'd31, 5'd31, 5'd31, "R7");
    do_req(2'b00, 1'b0, 1'b0, 2'b00, 5'd30, 5'd31, 5'd31, 5'd31, "R7");

    // linear sweep: pointers around word boundary, signed modifiers, all sizes
    for (int p = 0; p < 4; p++)
      for (int m = -3; m <= 3; m++)
        for (int sz = 0; sz < 4; sz++)
          for (int pr = 0; pr < 2; pr++)
            for (int w = 0; w < 2; w++) begin
              wr(5'd1, 32'h100 + 32'(p));
              wr(5'd2, 32'(m));
              do_req(2'(2'b00 + 2'(3*(sz & 1 & pr))), 1'(pr), 1'(w), 2'(sz),
                     5'd1, 5'd2, 5'd31, 5'd31, "");
            end

    // circular sweep, bases that are not aligned and one that is
    for (int bs = 0; bs < 2; bs++)
      for (int li = 0; li < 5; li++)
        for (int sz = 0; sz < 3; sz++) begin
          automatic int ln = (li == 0) ? 1 : (li == 1) ? 3 : (li == 2) ? 5 : (li == 3) ? 8 : 12;
          automatic int mm = ln >> sz;
          for (int o = 0; o < ln; o++)
            for (int m = -mm; m <= mm; m++) begin
              wr(5'd3, (bs == 0) ? 32'h0000_1003 : 32'hFFFF_FFF8);
              wr(5'd4, 32'(ln));
              wr(5'd1, sh_rf[3] + 32'(o));
              wr(5'd2, 32'(m));
              do_req(2'b01, 1'(m & 1), 1'b1, 2'(sz), 5'd1, 5'd2, 5'd3, 5'd4, "");
            end
        end

    // bit-reverse sweep
    for (int p = 0; p < 16; p++)
      for (int mi = 0; mi < 4; mi++)
        for (int sz = 0; sz < 3; sz++)
          for (int pr = 0; pr < 2; pr++) begin
            wr(5'd1, 32'(p));
            wr(5'd2, 32'd1 << mi);
            do_req(2'b10, 1'(pr), 1'b1, 2'(sz), 5'd1, 5'd2, 5'd31, 5'd31, "");
          end

    // R5/R8: chained 8-point reversed walk, each step reads the last write-back
    wr(5'd6, 32'd0);
    wr(5'd7, 32'd4);
    for (int k = 0; k < 8; k++) begin
      automatic bit [31:0] e = 32'(rev32(32'(k)) >> 29);
      chk(sh_rf[6] == e, "R5", "reversed order model", sh_rf[6], e);
      do_req(2'b10, 1'b0, 1'b0, 2'b00, 5'd6, 5'd7, 5'd31, 5'd31, "R8");
    end

    // R8: back-to-back linear chain
    wr(5'd8, 32'h40);
    wr(5'd9, 32'd3);
    for (int k = 0; k < 5; k++) do_req(2'b00, 1'b0, 1'b0, 2'b00, 5'd8, 5'd9, 5'd31, 5'd31, "R8");

    // R8: port write and write-back on the same index in the same edge
    wr(5'd1, 32'h500);
    wr(5'd2, 32'd1);
    drive(2'b00, 1'b0, 1'b0, 2'b00, 5'd1, 5'd2, 5'd31, 5'd31);
    rf_wr_en = 1'b1; rf_wr_idx = 5'd1; rf_wr_data = 32'h777;
    @(posedge clk); @(negedge clk);
    rf_wr_en = 1'b0; req_valid = 1'b0;
    chk(rsp_addr == 32'h500, "R8", "conflict address", rsp_addr, 32'h500);
    chk(rsp_ptr_new == 32'h501, "R8", "conflict pointer", rsp_ptr_new, 32'h501);
    sh_rf[1] = 32'h777;
    do_req(2'b00, 1'b0, 1'b0, 2'b00, 5'd1, 5'd31, 5'd31, 5'd31, "R8");

    // R7: index 31 ignores port writes and write-backs
    wr(5'd31, 32'hDEAD_BEEF);
    do_req(2'b00, 1'b0, 1'b0, 2'b00, 5'd31, 5'd2, 5'd31, 5'd31, "R7");
    do_req(2'b00, 1'b0, 1'b0, 2'b00, 5'd31, 5'd2, 5'd31, 5'd31, "R7");

    // R10: stall holds the response and blocks the next request
    wr(5'd1, 32'h300);
    wr(5'd3, 32'h902);
    rsp_ready = 1'b0;
    drive(2'b00, 1'b0, 1'b0, 2'b01, 5'd1, 5'd2, 5'd31, 5'd31);
    @(posedge clk); @(negedge clk);
    drive(2'b00, 1'b0, 1'b0, 2'b10, 5'd3, 5'd2, 5'd31, 5'd31);
    chk(rsp_valid == 1'b1, "R9", "stall rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rsp_addr == 32'h300, "R10", "stall address", rsp_addr, 32'h300);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R10", "req_ready during stall", 32'(req_ready), 32'd0);
      chk(rsp_valid == 1'b1, "R10", "rsp_valid during stall", 32'(rsp_valid), 32'd1);
      chk(rsp_addr == 32'h300, "R10", "held address", rsp_addr, 32'h300);
      chk(rsp_ptr_new == 32'h302, "R10", "held pointer", rsp_ptr_new, 32'h302);
    end
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_addr == 32'h902, "R10", "queued request address", rsp_addr, 32'h902);
    chk(rsp_ptr_new == 32'h906, "R3", "quad step", rsp_ptr_new, 32'h906);
    chk(rsp_align_fault == 1'b1, "R6", "quad misaligned", 32'(rsp_align_fault), 32'd1);
    sh_rf[1] = 32'h302; sh_rf[3] = 32'h906;
    @(posedge clk); @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", "rsp_valid after drain", 32'(rsp_valid), 32'd0);
    do_req(2'b00, 1'b0, 1'b0, 2'b00, 5'd1, 5'd31, 5'd31, 5'd31, "R8");
    do_req(2'b00, 1'b0, 1'b0, 2'b00, 5'd3, 5'd31, 5'd31, 5'd31, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule